// File: doc/BRIEF.md
# PWM Time-Base Counter with Cascaded Prescaler

This block is the timing core of a pulse-width modulator channel pair. A 16-bit counter steps once for each prescaled tick and sweeps between zero and an active period value. It can count upward and wrap, count downward and reload, bounce between the two ends, or stay frozen. A single control word selects the sweep mode, how period writes take effect, and two prescaler fields that are multiplied together to set the tick rate.

Period writes either land in the active period at once or go to a staging register. A staged value is copied into the active period on the step where the counter arrives at zero, so a running waveform never sees a cut-short cycle. Four event flags are decoded from the counter: at zero, at period, and at each of two compare values. The compare flags are split by the direction of the step that produced the current count. Downstream action logic turns these flags into output edges.

Top module: `pwm_timebase`

## Requirements
- R1: While reset is held, the count is 0, the direction flag is low (upward) and the active period is 0.
- R2: With low-speed field L in control bits [12:10] and high-speed field H in bits [9:7], the counter steps once every D = 2^L × (H = 0 ? 1 : 2H) clocks.
- R3: After either prescaler field changes, the first step comes D+1 clocks after the clock in which the new field value is first presented, where D is the new divide.
- R4: Mode 00 in bits [1:0] counts upward and goes from the period value to 0 on the next step, with the direction flag low.
- R5: Mode 01 counts downward and goes from 0 to the period value on the next step, with the direction flag high.
- R6: Mode 10 counts up to the period and back down to 0, so one cycle lasts 2P steps. The direction flag shows the direction of the step that produced the current count: high at 0 and on the way down, low at the period and on the way up.
- R7: Mode 11 holds the count and the direction flag, and all six event flags stay low.
- R8: With control bit 3 set, a period write reaches the active period on the clock that takes it.
- R9: With control bit 3 clear, a period write goes to a staging register. The active period keeps its old value until the step that takes the counter to 0, and on that step it takes the staged value.
- R10: The zero and period flags are high exactly while a non-frozen counter equals 0 or the active period, so each lasts one tick interval.
- R11: Each compare flag has an up and a down variant. The up variant is high while the count equals its compare value and the direction flag is low. The down variant is high while they are equal and the direction flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 16 | Mode [1:0], immediate period load [3], high-speed divide [9:7], low-speed divide [12:10] |
| prd_we | input | 1 | Period write strobe, one clock per write |
| prd_wdata | input | 16 | Period value to write |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| tb_count | output | 16 | Current count |
| tb_down | output | 1 | High when the last step was downward |
| prd_active | output | 16 | Active period value |
| evt_zero | output | 1 | Count equals 0 |
| evt_period | output | 1 | Count equals the active period |
| evt_ca_up | output | 1 | Count equals compare A, moving up |
| evt_ca_dn | output | 1 | Count equals compare A, moving down |
| evt_cb_up | output | 1 | Count equals compare B, moving up |
| evt_cb_dn | output | 1 | Count equals compare B, moving down |

## Verification
The properties assume that reset is held for at least one clock and that the control word, the compare values and the write strobe change only between clock edges, never at an edge. The stimulus meets this by driving every input just after the falling edge. The step-by-step properties also assume the period is never lowered below the running count. The stimulus keeps to this because it only raises the period through the staging register and sets lower values while the count is still below them.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

    localparam int CTRL_W   = 16;
    localparam int LS_W     = 3;
    localparam int HS_W     = 3;
    localparam int MODE_LSB = 0;
    localparam int LOAD_BIT = 3;
    localparam int HS_LSB   = 7;
    localparam int LS_LSB   = 10;

    localparam int LS_MAX  = (1 << LS_W) - 1;
    localparam int HS_MAX  = (1 << HS_W) - 1;
    localparam int MAX_DIV = (1 << LS_MAX) * 2 * HS_MAX;
    localparam int PS_W    = $clog2(MAX_DIV);

    typedef enum logic [1:0] {
        TB_UP     = 2'b00,
        TB_DOWN   = 2'b01,
        TB_UPDOWN = 2'b10,
        TB_HOLD   = 2'b11
    } tb_mode_e;

    typedef struct packed {
        logic [LS_W-1:0] ls;
        logic [HS_W-1:0] hs;
        logic            imm;
        tb_mode_e        mode;
    } tb_ctrl_t;

    function automatic tb_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
        tb_ctrl_t c;
        c.mode = tb_mode_e'(w[MODE_LSB +: 2]);
        c.imm  = w[LOAD_BIT];
        c.hs   = w[HS_LSB +: HS_W];
        c.ls   = w[LS_LSB +: LS_W];
        return c;
    endfunction

    // Terminal value of the prescale counter: total divide minus one
    function automatic logic [PS_W-1:0] ps_last(input logic [LS_W-1:0] ls,
                                                 input logic [HS_W-1:0] hs);
        int hd;
        int d;
        hd = (hs == '0) ? 1 : 2 * int'(hs);
        d  = hd << ls;
        return PS_W'(d - 1);
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_timebase_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [LS_W-1:0] ls,
    input  logic [HS_W-1:0] hs,
    output logic            tick
);
    logic [LS_W-1:0] ls_q;
    logic [HS_W-1:0] hs_q;
    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] last;
    logic            changed;

    assign last    = ps_last(ls, hs);
    assign changed = (ls != ls_q) || (hs != hs_q);
    assign tick    = !changed && (pcnt >= last);

    always_ff @(posedge clk) begin
        if (rst) begin
            ls_q <= '0;
            hs_q <= '0;
            pcnt <= '0;
        end else begin
            ls_q <= ls;
            hs_q <= hs;
            if (changed || tick) pcnt <= '0;
            else                 pcnt <= pcnt + 1'b1;
        end
    end

    // R2: with a divide above one, ticks never come on adjacent clocks
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && last != '0) |=> !tick);

    // R3: a field change restarts the divide interval from zero
    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        changed |=> (pcnt == '0));

endmodule

// File: rtl/pwm_period_reg.sv
module pwm_period_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             imm,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             zero_load,
    output logic [CNT_W-1:0] active
);
    logic [CNT_W-1:0] staged;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
            active <= '0;
        end else begin
            if (wr_en) staged <= wr_data;
            if (wr_en && imm)   active <= wr_data;
            else if (zero_load) active <= staged;
        end
    end

    // R8: an immediate write reaches the active period at once
    a_r8_immediate: assert property (@(posedge clk) disable iff (rst)
        (wr_en && imm) |=> (active == $past(wr_data)));

    // R9: without a zero step or immediate write the active period holds
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!zero_load && !(wr_en && imm)) |=> $stable(active));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  tb_mode_e         mode,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic             zero_load
);
    logic [CNT_W-1:0] nxt_cnt;
    logic             nxt_down;
    logic             step;

    always_comb begin
        nxt_cnt  = cnt;
        nxt_down = down;
        unique case (mode)
            TB_UP: begin
                nxt_down = 1'b0;
                nxt_cnt  = (cnt >= prd) ? '0 : cnt + 1'b1;
            end
            TB_DOWN: begin
                nxt_down = 1'b1;
                nxt_cnt  = (cnt == '0) ? prd : cnt - 1'b1;
            end
            TB_UPDOWN: begin
                if (!down) begin
                    if (cnt >= prd) begin
                        nxt_down = 1'b1;
                        nxt_cnt  = (cnt == '0) ? '0 : cnt - 1'b1;
                    end else begin
                        nxt_cnt  = cnt + 1'b1;
                    end
                end else begin
                    if (cnt == '0) begin
                        nxt_down = 1'b0;
                        nxt_cnt  = (prd == '0) ? '0 : CNT_W'(1);
                    end else begin
                        nxt_cnt  = cnt - 1'b1;
                    end
                end
            end
            default: begin
                nxt_cnt  = cnt;
                nxt_down = down;
            end
        endcase
    end

    assign step      = tick && (mode != TB_HOLD);
    assign zero_load = step && (nxt_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            down <= 1'b0;
        end else if (step) begin
            cnt  <= nxt_cnt;
            down <= nxt_down;
        end
    end

    // R2: the counter only moves on a prescaled tick
    a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(cnt) && $stable(down)));

    // R4: below the period, up mode advances by one
    a_r4_up_step: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == TB_UP && cnt < prd) |=> (cnt == $past(cnt) + 1'b1));

    // R5: down mode reloads the period after zero
    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == TB_DOWN && cnt == '0) |=> (cnt == $past(prd)));

    // R6: up-down mode turns downward at the period
    a_r6_turn: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == TB_UPDOWN && !down && cnt == prd && prd != '0) |=> down);

    // R7: frozen mode never moves the counter
    a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
        (mode == TB_HOLD) |=> ($stable(cnt) && $stable(down)));

endmodule

// File: rtl/pwm_events.sv
module pwm_events #(
    parameter int CNT_W = 16
) (
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic             down,
    input  logic [CNT_W-1:0] prd,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output logic             ev_zero,
    output logic             ev_prd,
    output logic             ev_ca_up,
    output logic             ev_ca_dn,
    output logic             ev_cb_up,
    output logic             ev_cb_dn
);
    logic hit_a;
    logic hit_b;

    assign hit_a    = run && (cnt == cmp_a);
    assign hit_b    = run && (cnt == cmp_b);
    assign ev_zero  = run && (cnt == '0);
    assign ev_prd   = run && (cnt == prd);
    assign ev_ca_up = hit_a && !down;
    assign ev_ca_dn = hit_a &&  down;
    assign ev_cb_up = hit_b && !down;
    assign ev_cb_dn = hit_b &&  down;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              prd_we,
    input  logic [CNT_W-1:0]  prd_wdata,
    input  logic [CNT_W-1:0]  cmp_a,
    input  logic [CNT_W-1:0]  cmp_b,
    output logic [CNT_W-1:0]  tb_count,
    output logic              tb_down,
    output logic [CNT_W-1:0]  prd_active,
    output logic              evt_zero,
    output logic              evt_period,
    output logic              evt_ca_up,
    output logic              evt_ca_dn,
    output logic              evt_cb_up,
    output logic              evt_cb_dn
);
    tb_ctrl_t ctrl;
    logic     tick;
    logic     zero_load;

    assign ctrl = decode_ctrl(ctrl_word);

    pwm_prescaler u_presc (
        .clk  (clk),
        .rst  (rst),
        .ls   (ctrl.ls),
        .hs   (ctrl.hs),
        .tick (tick)
    );

    pwm_period_reg #(.CNT_W(CNT_W)) u_prd (
        .clk       (clk),
        .rst       (rst),
        .imm       (ctrl.imm),
        .wr_en     (prd_we),
        .wr_data   (prd_wdata),
        .zero_load (zero_load),
        .active    (prd_active)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (ctrl.mode),
        .prd       (prd_active),
        .cnt       (tb_count),
        .down      (tb_down),
        .zero_load (zero_load)
    );

    pwm_events #(.CNT_W(CNT_W)) u_evt (
        .run      (ctrl.mode != TB_HOLD),
        .cnt      (tb_count),
        .down     (tb_down),
        .prd      (prd_active),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .ev_zero  (evt_zero),
        .ev_prd   (evt_period),
        .ev_ca_up (evt_ca_up),
        .ev_ca_dn (evt_ca_dn),
        .ev_cb_up (evt_cb_up),
        .ev_cb_dn (evt_cb_dn)
    );

    // R10: a frozen counter raises no event flag
    a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        (ctrl_word[1:0] == 2'b11) |-> !(evt_zero || evt_period || evt_ca_up ||
                                        evt_ca_dn || evt_cb_up || evt_cb_dn));

    // R11: the up and down compare flags of one channel never coincide
    a_r11_dir_split: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_ca_up, evt_ca_dn}) && $onehot0({evt_cb_up, evt_cb_dn}));

endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] ctrl_word;
    logic        prd_we;
    logic [15:0] prd_wdata;
    logic [15:0] cmp_a;
    logic [15:0] cmp_b;
    logic [15:0] tb_count;
    logic        tb_down;
    logic [15:0] prd_active;
    logic        evt_zero, evt_period, evt_ca_up, evt_ca_dn, evt_cb_up, evt_cb_dn;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    pwm_timebase i_pwm_timebase (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .prd_we(prd_we),
        .prd_wdata(prd_wdata), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .tb_count(tb_count), .tb_down(tb_down), .prd_active(prd_active),
        .evt_zero(evt_zero), .evt_period(evt_period),
        .evt_ca_up(evt_ca_up), .evt_ca_dn(evt_ca_dn),
        .evt_cb_up(evt_cb_up), .evt_cb_dn(evt_cb_dn)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int bdiv(input int ls, input int hs);
        return (1 << ls) * ((hs == 0) ? 1 : 2 * hs);
    endfunction

    // ctrl fields: mode [1:0], immediate [3], high-speed [9:7], low-speed [12:10]
    task automatic set_ctrl(input int mode, input int imm, input int hs, input int ls);
        ctrl_word = {3'b000, 3'(ls), 3'(hs), 3'b000, 1'(imm), 1'b0, 2'(mode)};
    endtask

    task automatic write_prd(input int v);
        prd_we    = 1'b1;
        prd_wdata = 16'(v);
        @(negedge clk);
        prd_we    = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int prev_ls, prev_hs, n, exp, m, d, top;
        logic [15:0] prev;
        logic        exp_dn;

        rst = 1'b1; ctrl_word = '0; prd_we = 1'b0; prd_wdata = '0;
        cmp_a = 16'd2; cmp_b = 16'd4;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 count", int'(tb_count), 0);
        chk("R1 dir", int'(tb_down), 0);
        chk("R1 period", int'(prd_active), 0);
        rst = 1'b0;

        // R8: immediate period write
        set_ctrl(0, 1, 0, 0);
        write_prd(5);
        chk("R8 immediate period", int'(prd_active), 5);

        // R2/R3: prescaler sweep
        prev_ls = 0; prev_hs = 0;
        for (int sel = 0; sel < 19; sel++) begin
            int ls, hs;
            if (sel < 16) begin ls = sel / 4; hs = sel % 4; end
            else if (sel == 16) begin ls = 7; hs = 0; end
            else if (sel == 17) begin ls = 0; hs = 7; end
            else begin ls = 7; hs = 7; end
            d = bdiv(ls, hs);
            prev = tb_count;
            set_ctrl(0, 1, hs, ls);
            n = 0;
            do begin @(negedge clk); n++; end while (tb_count == prev && n < 5000);
            if (ls != prev_ls || hs != prev_hs)
                chk("R3 first step after field change", n, d + 1);
            prev = tb_count;
            n = 0;
            do begin @(negedge clk); n++; end while (tb_count == prev && n < 5000);
            chk("R2 step interval", n, d);
            prev_ls = ls; prev_hs = hs;
        end

        // R4/R10/R11: up mode, divide 1
        set_ctrl(0, 1, 0, 0);
        for (int g = 0; g < 4000 && tb_count != 0; g++) @(negedge clk);
        for (int k = 0; k < 12; k++) begin
            exp = k % 6;
            chk("R4 up count", int'(tb_count), exp);
            chk("R4 up dir", int'(tb_down), 0);
            chk("R10 zero flag", int'(evt_zero), int'(exp == 0));
            chk("R10 period flag", int'(evt_period), int'(exp == 5));
            chk("R11 ca up", int'(evt_ca_up), int'(exp == 2));
            chk("R11 cb up", int'(evt_cb_up), int'(exp == 4));
            chk("R11 ca dn", int'(evt_ca_dn), 0);
            @(negedge clk);
        end

        // R5/R11: down mode
        set_ctrl(1, 1, 0, 0);
        for (int g = 0; g < 4000 && !(tb_count == 0 && tb_down); g++) @(negedge clk);
        for (int k = 0; k < 12; k++) begin
            exp = (6 - (k % 6)) % 6;
            chk("R5 down count", int'(tb_count), exp);
            chk("R5 down dir", int'(tb_down), 1);
            chk("R11 ca dn", int'(evt_ca_dn), int'(exp == 2));
            chk("R11 cb dn", int'(evt_cb_dn), int'(exp == 4));
            chk("R11 ca up", int'(evt_ca_up), 0);
            @(negedge clk);
        end

        // R6/R10/R11: up-down mode
        set_ctrl(2, 1, 0, 0);
        for (int g = 0; g < 4000 && !(tb_count == 0 && tb_down); g++) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            m = k % 10;
            exp = (m <= 5) ? m : 10 - m;
            exp_dn = (m == 0) || (m > 5);
            chk("R6 updown count", int'(tb_count), exp);
            chk("R6 updown dir", int'(tb_down), int'(exp_dn));
            chk("R10 period flag", int'(evt_period), int'(exp == 5));
            chk("R11 ca up", int'(evt_ca_up), int'(exp == 2 && !exp_dn));
            chk("R11 ca dn", int'(evt_ca_dn), int'(exp == 2 && exp_dn));
            chk("R11 cb dn", int'(evt_cb_dn), int'(exp == 4 && exp_dn));
            @(negedge clk);
        end

        // R7/R10: freeze
        set_ctrl(3, 1, 0, 0);
        @(negedge clk);
        prev = tb_count;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R7 frozen count", int'(tb_count), int'(prev));
            chk("R7 frozen flags", int'({evt_zero, evt_period, evt_ca_up,
                                         evt_ca_dn, evt_cb_up, evt_cb_dn}), 0);
        end

        // R9: staged period load at zero
        set_ctrl(0, 0, 0, 0);
        for (int g = 0; g < 4000 && tb_count != 2; g++) @(negedge clk);
        write_prd(8);
        for (int g = 0; g < 20 && tb_count != 0; g++) begin
            chk("R9 staged period not yet active", int'(prd_active), 5);
            @(negedge clk);
        end
        chk("R9 loaded at zero step", int'(prd_active), 8);
        top = 0;
        @(negedge clk);
        for (int g = 0; g < 20 && tb_count != 0; g++) begin
            if (int'(tb_count) > top) top = int'(tb_count);
            @(negedge clk);
        end
        chk("R9 new period top", top, 8);

        summary();
    end

endmodule